// File: doc/BRIEF.md
# Nine-Bit Shift-Register Random Byte Source

This block supplies pseudo-random bytes to a processor's random-number instruction. It holds a 9-bit linear-feedback shift register. Only the low eight bits of that register reach the output. A 9-bit state is used because every value of an 8-bit state can never repeat inside a single period, and a maximal 8-bit register would therefore never produce the all-ones byte. With a 9-bit state, the 8-bit view covers every byte value, 0xFF included.

The processor pulses an advance strobe each time it wants a new value. On each advance, the state is rotated right by one place, and the complement of the old least significant bit is then XORed into bit 4. The processor can also load a 9-bit seed. A load wins over an advance that arrives in the same cycle. The output comes straight from the state register, so a new byte appears one clock edge after the request. Masking the byte with an instruction operand and writing it to a register is left to the processor.

Top module: `rng_byte_gen`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and after it is released, the state is the seed 0x001, so `rnd_o` reads 0x01 until the first advance or load.
- R2: On a clock edge with `adv_i` high and `load_i` low, the new state is the old state rotated right by one place (old bit 0 moves to bit 8), XORed with a mask that holds the complement of the old bit 0 at bit 4 and zeros elsewhere.
- R3: On a clock edge with both `adv_i` and `load_i` low, the state and `rnd_o` keep their values.
- R4: On a clock edge with `load_i` high, the state takes `seed_i`, and `rnd_o` shows `seed_i[7:0]` after that edge.
- R5: When `load_i` and `adv_i` are both high on the same edge, the load is applied and no advance takes place.
- R6: `rnd_o` is always bits 7:0 of the state, so 0xFF can be produced. For example, one advance from state 0x1DE gives state 0x0FF, and a further advance gives 0x17F, so `rnd_o` reads 0x7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance the register by one step |
| load_i | input | 1 | Load `seed_i` into the state |
| seed_i | input | 9 | Seed value for a load |
| rnd_o | output | 8 | Low byte of the state |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. The bench drives the inputs on the falling edge. It updates its own model of the 9-bit state at the following rising edge, then compares `rnd_o` 2 ns after that edge, which is well clear of any edge. The reset value is compared while reset is still asserted and again after reset is released. The 0xFF case and the step that follows it are driven as a directed sequence, separate from the random stimulus.

// File: rtl/rng9_pkg.sv
package rng9_pkg;
  localparam int STATE_W  = 9;
  localparam int OUT_W    = 8;
  localparam int TAP_BIT  = 4;
  localparam logic [STATE_W-1:0] RESET_SEED = 9'h001;

  // One step: rotate right, then flip the tap bit when the old LSB is clear.
  function automatic logic [STATE_W-1:0] lfsr_next(input logic [STATE_W-1:0] s);
    logic [STATE_W-1:0] mask;
    mask          = '0;
    mask[TAP_BIT] = ~s[0];
    return {s[0], s[STATE_W-1:1]} ^ mask;
  endfunction
endpackage

// File: rtl/rng9_step.sv
module rng9_step
  import rng9_pkg::*;
#(
  parameter int SW = STATE_W
) (
  input  logic [SW-1:0] cur_i,
  output logic [SW-1:0] nxt_o
);
  always_comb nxt_o = lfsr_next(cur_i);
endmodule

// File: rtl/rng9_state.sv
module rng9_state
  import rng9_pkg::*;
#(
  parameter int              SW   = STATE_W,
  parameter logic [SW-1:0]   SEED = RESET_SEED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_evt,
  input  logic          load_evt,
  input  logic [SW-1:0] seed_i,
  input  logic [SW-1:0] step_i,
  output logic [SW-1:0] state_o
);
  logic [SW-1:0] state_d;

  // A load wins over an advance in the same cycle.
  always_comb begin
    state_d = state_o;
    if (load_evt)      state_d = seed_i;
    else if (adv_evt)  state_d = step_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= SEED;
    else        state_o <= state_d;
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_evt && !load_evt) |=> $stable(state_o)); // R3

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (state_o == $past(seed_i))); // R4 R5
endmodule

// File: rtl/rng_byte_gen.sv
module rng_byte_gen
  import rng9_pkg::*;
#(
  parameter int SW = STATE_W,
  parameter int OW = OUT_W,
  parameter int TB = TAP_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          load_i,
  input  logic [SW-1:0] seed_i,
  output logic [OW-1:0] rnd_o
);
  logic          adv_evt;
  logic          load_evt;
  logic          step_evt;
  logic [SW-1:0] state_q;
  logic [SW-1:0] state_nx;

  assign adv_evt  = adv_i;
  assign load_evt = load_i;
  assign step_evt = adv_evt && !load_evt;

  rng9_step #(.SW(SW)) u_step (
    .cur_i (state_q),
    .nxt_o (state_nx)
  );

  rng9_state #(.SW(SW), .SEED(RESET_SEED)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_evt  (adv_evt),
    .load_evt (load_evt),
    .seed_i   (seed_i),
    .step_i   (state_nx),
    .state_o  (state_q)
  );

  assign rnd_o = state_q[OW-1:0];

  AST_ROTATE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (state_q[SW-1] == $past(state_q[0]))); // R2

  AST_TAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (state_q[TB] == ($past(state_q[TB+1]) ^ ~$past(state_q[0])))); // R2

  AST_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (rnd_o[OW-1] == $past(state_q[OW]))); // R6
endmodule

// File: tb/sim_rng_byte_gen.sv
module sim_rng_byte_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adv_i = 1'b0;
  logic       load_i = 1'b0;
  logic [8:0] seed_i = '0;
  logic [7:0] rnd_o;

  int vectors = 0;
  int errors  = 0;
  logic [8:0] model = 9'h001;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rng_byte_gen u0 (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .load_i(load_i),
    .seed_i(seed_i), .rnd_o(rnd_o)
  );

  function automatic logic [8:0] ref_step(input logic [8:0] s);
    logic [8:0] r;
    r = (s >> 1) | ((s & 9'h001) << 8);
    if (s[0] == 1'b0) r = r ^ 9'h010;
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    vectors++;
    if (rnd_o !== exp) begin
      errors++;
      $display("FAIL %s: rnd_o=%02h expected %02h", req, rnd_o, exp);
    end
  endtask

  task automatic cycle(input logic a, input logic l, input logic [8:0] s, input string req);
    @(negedge clk);
    adv_i = a; load_i = l; seed_i = s;
    @(posedge clk);
    if (l)      model = s;
    else if (a) model = ref_step(model);
    #2;
    check(req, model[7:0]);
  endtask

  initial begin
    #50000000;
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #23;
    check("R1 in reset", 8'h01);
    @(negedge clk); rst_n = 1'b1;
    #12;
    check("R1 after release", 8'h01);
    cycle(1'b0, 1'b0, 9'h000, "R3 idle");
    cycle(1'b1, 1'b0, 9'h000, "R2 first step");   // 0x100 -> 00
    cycle(1'b1, 1'b0, 9'h000, "R2 second step");  // 0x090 -> 90
    cycle(1'b0, 1'b0, 9'h1AB, "R3 hold with seed noise");
    cycle(1'b0, 1'b1, 9'h1DE, "R4 load");
    cycle(1'b1, 1'b0, 9'h000, "R6 reach FF");     // 0x0FF
    if (model != 9'h0FF) begin errors++; $display("FAIL R6: model=%03h expected 0ff", model); end
    cycle(1'b1, 1'b0, 9'h000, "R6 after FF");     // 0x17F -> 7F
    cycle(1'b1, 1'b1, 9'h055, "R5 load beats advance");
    cycle(1'b0, 1'b1, 9'h133, "R4 load high bit");
    cycle(1'b1, 1'b0, 9'h000, "R2 step from loaded");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cycle(r[0] | r[1], r[4:2] == 3'd0, r[13:5], "R2 R3 R4 R5 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule